// File: doc/BRIEF.md
# I2C Master Arbitration and Collision Guard

This block sits beside the bit sequencer of an I2C master that shares its bus with other masters. It watches the sampled SDA and SCL lines, spots Start and Stop conditions, and keeps two status bits that show whether the bus is owned or free. While the master is driving anything onto the bus, the block compares the level the master intends on SDA with the level it actually sees. It does this only while SCL is sampled high. If the master has released SDA but the line reads low, another master has won arbitration.

When it loses, the block sets a sticky collision flag. It pulses an event interrupt and a master-abort strobe, and it asks for both lines to be released. What it clears next depends on what was in progress. A lost data byte drops the transmit-buffer-full flag. A lost Start, Restart, Stop or Acknowledge drops only the enable bit of that condition. The block then keeps watching the bus and pulses the interrupt again when a Stop shows that the bus is free. A new write to the transmit register restarts the byte at its first bit. A new Start is taken only on a free bus with the collision flag cleared.

Top module: `i2c_arb_guard`

## Requirements
- R1: A Start (SDA sampled falling while SCL is sampled high on two successive clocks) sets `s_bit` and clears `p_bit` one clock later. After reset both bits are 0, and `bus_free` equals the inverse of `s_bit`.
- R2: A Stop (SDA sampled rising while SCL is sampled high on two successive clocks) sets `p_bit` and clears `s_bit` one clock later.
- R3: A collision is declared only when `op` is not idle (code 0), `scl_in` is 1, `sda_drv` is 1 and `sda_in` is 0. A low SDA while SCL is low, a low SDA that the master drives itself, and an idle `op` never cause one.
- R4: One clock after a collision, `coll` is 1 and stays 1. In that same clock `irq` and `mst_abort` are 1 for one cycle and `line_rel` is 1.
- R5: A collision with `op` = data (code 5) clears `tbf` and leaves `cond_en` unchanged.
- R6: A collision during a condition clears only the matching bit of `cond_en` and leaves `tbf` unchanged. The codes are start=1, restart=2, stop=3, ack=4, and they map to `cond_en` bits 0, 1, 2 and 3.
- R7: While `coll` is 1, a detected Stop pulses `irq` for one cycle.
- R8: `bit_ptr` holds its value through a collision. A `tx_wr` pulse sets `tbf` and returns `bit_ptr` to 0.
- R9: A Start request (`cond_req` bit 0) sets `cond_en` bit 0 only when `s_bit` is 0 and `coll` is 0. An accepted Start clears `line_rel`.
- R10: `coll_clr` clears `coll`.
- R11: With `op` = data and `tbf` = 1, each sampled SCL falling edge advances `bit_ptr`. The edge after `bit_ptr` reaches DATA_BITS-1 clears `tbf` and `bit_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| sda_drv | input | 1 | Level the master intends on SDA (1 = released) |
| op | input | 3 | Operation in progress: 0 idle, 1 start, 2 restart, 3 stop, 4 ack, 5 data |
| cond_req | input | 4 | Condition requests: start, restart, stop, ack |
| cond_done | input | 4 | Sequencer completion pulses clearing condition bits |
| tx_wr | input | 1 | Transmit register write strobe |
| coll_clr | input | 1 | Clears the collision flag |
| coll | output | 1 | Sticky collision flag |
| s_bit | output | 1 | Start seen last |
| p_bit | output | 1 | Stop seen last |
| bus_free | output | 1 | Bus may be claimed |
| tbf | output | 1 | Transmit buffer full |
| bit_ptr | output | 3 | Index of the next data bit to send |
| cond_en | output | 4 | Condition enable bits |
| irq | output | 1 | Master event interrupt pulse |
| mst_abort | output | 1 | One-cycle master state reset |
| line_rel | output | 1 | Release both SDA and SCL |

## Verification
The hardest case to reach is a lost arbitration in the middle of a byte, because it needs three things at once: a held write, several counted SCL falls, and a low SDA raised under SCL high. The stimulus gets there in steps. It lowers SDA while SCL is low, which must be ignored, and then raises SCL so the mismatch shows. It then checks that the bit position is held and is reset only by the next write. A collision during an Acknowledge is set up with a Start already enabled, so that clearing only the matching bit can be seen. A random phase toggles both lines with the master idle and follows S and P against a bench model.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  localparam int NCOND = 4;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_START   = 3'd1,
    OP_RESTART = 3'd2,
    OP_STOP    = 3'd3,
    OP_ACK     = 3'd4,
    OP_DATA    = 3'd5
  } op_e;

  // one-hot mask of the condition enable bit belonging to an operation
  function automatic logic [NCOND-1:0] cond_mask(op_e o);
    logic [NCOND-1:0] m;
    m = '0;
    case (o)
      OP_START:   m[0] = 1'b1;
      OP_RESTART: m[1] = 1'b1;
      OP_STOP:    m[2] = 1'b1;
      OP_ACK:     m[3] = 1'b1;
      default:    m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon (
  input  logic clk,
  input  logic rst,
  input  logic sda_in,
  input  logic scl_in,
  output logic s_bit,
  output logic p_bit,
  output logic start_det,
  output logic stop_det,
  output logic scl_fall
);
  logic sda_q, scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_in;
      scl_q <= scl_in;
    end
  end

  always_comb begin
    start_det = scl_q & scl_in & sda_q & ~sda_in;
    stop_det  = scl_q & scl_in & ~sda_q & sda_in;
    scl_fall  = scl_q & ~scl_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_bit <= 1'b0;
      p_bit <= 1'b0;
    end else if (start_det) begin
      s_bit <= 1'b1;
      p_bit <= 1'b0;
    end else if (stop_det) begin
      s_bit <= 1'b0;
      p_bit <= 1'b1;
    end
  end

  assert_start_sets_s_R1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (s_bit && !p_bit));
  assert_stop_sets_p_R2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (p_bit && !s_bit));
endmodule

// File: rtl/i2c_coll_det.sv
module i2c_coll_det
  import i2c_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sda_in,
  input  logic scl_in,
  input  logic sda_drv,
  input  op_e  op,
  input  logic stop_det,
  input  logic coll_clr,
  input  logic start_acc,
  output logic coll_evt,
  output logic coll,
  output logic irq,
  output logic mst_abort,
  output logic line_rel
);
  logic mismatch;

  always_comb begin
    mismatch = scl_in & sda_drv & ~sda_in;
    coll_evt = ~coll & (op != OP_IDLE) & mismatch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coll      <= 1'b0;
      irq       <= 1'b0;
      mst_abort <= 1'b0;
      line_rel  <= 1'b0;
    end else begin
      irq       <= coll_evt | (coll & stop_det);
      mst_abort <= coll_evt;
      if (coll_evt)      coll <= 1'b1;
      else if (coll_clr) coll <= 1'b0;
      if (coll_evt)       line_rel <= 1'b1;
      else if (start_acc) line_rel <= 1'b0;
    end
  end

  assert_coll_response_R4: assert property (@(posedge clk) disable iff (rst)
    coll_evt |=> (coll && irq && mst_abort && line_rel));
  assert_coll_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(coll) |-> $past(scl_in && sda_drv && !sda_in && (op != OP_IDLE)));
  assert_stop_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (coll && stop_det) |=> irq);
endmodule

// File: rtl/i2c_tx_track.sv
module i2c_tx_track
  import i2c_arb_pkg::*;
#(
  parameter int DATA_BITS = 8,
  localparam int BIT_W = $clog2(DATA_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_wr,
  input  logic             coll_evt,
  input  logic             coll,
  input  op_e              op,
  input  logic             scl_fall,
  output logic             tbf,
  output logic [BIT_W-1:0] bit_ptr
);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_BITS - 1);
  logic in_data;

  always_comb in_data = (op == OP_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      tbf     <= 1'b0;
      bit_ptr <= '0;
    end else if (tx_wr) begin
      tbf     <= 1'b1;
      bit_ptr <= '0;
    end else if (coll_evt && in_data) begin
      tbf     <= 1'b0;
    end else if (scl_fall && in_data && tbf && !coll) begin
      if (bit_ptr == LAST) begin
        tbf     <= 1'b0;
        bit_ptr <= '0;
      end else begin
        bit_ptr <= bit_ptr + 1'b1;
      end
    end
  end

  assert_data_coll_clears_tbf_R5: assert property (@(posedge clk) disable iff (rst)
    (coll_evt && in_data && !tx_wr) |=> !tbf);
  assert_write_rewinds_R8: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> (tbf && bit_ptr == '0));
  assert_ptr_range_R11: assert property (@(posedge clk) disable iff (rst)
    bit_ptr <= LAST);
endmodule

// File: rtl/i2c_cond_ctl.sv
module i2c_cond_ctl
  import i2c_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NCOND-1:0] cond_req,
  input  logic [NCOND-1:0] cond_done,
  input  logic             s_bit,
  input  logic             coll,
  input  logic             coll_evt,
  input  op_e              op,
  output logic             start_acc,
  output logic [NCOND-1:0] cond_en
);
  logic [NCOND-1:0] kill, take;

  always_comb begin
    start_acc = cond_req[0] & ~s_bit & ~coll;
    kill      = coll_evt ? cond_mask(op) : '0;
    take      = {cond_req[NCOND-1:1], start_acc};
  end

  for (genvar i = 0; i < NCOND; i++) begin : g_cond
    always_ff @(posedge clk) begin
      if (rst)                            cond_en[i] <= 1'b0;
      else if (kill[i] || cond_done[i])   cond_en[i] <= 1'b0;
      else if (take[i])                   cond_en[i] <= 1'b1;
    end
  end

  assert_start_gate_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cond_en[0]) |-> $past(!coll && !s_bit));
  assert_cond_kill_R6: assert property (@(posedge clk) disable iff (rst)
    (coll_evt && op == OP_ACK) |=> !cond_en[3]);
endmodule

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard
  import i2c_arb_pkg::*;
#(
  parameter int DATA_BITS = 8,
  localparam int BIT_W = $clog2(DATA_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_in,
  input  logic             scl_in,
  input  logic             sda_drv,
  input  logic [2:0]       op,
  input  logic [NCOND-1:0] cond_req,
  input  logic [NCOND-1:0] cond_done,
  input  logic             tx_wr,
  input  logic             coll_clr,
  output logic             coll,
  output logic             s_bit,
  output logic             p_bit,
  output logic             bus_free,
  output logic             tbf,
  output logic [BIT_W-1:0] bit_ptr,
  output logic [NCOND-1:0] cond_en,
  output logic             irq,
  output logic             mst_abort,
  output logic             line_rel
);
  op_e  op_t;
  logic start_det, stop_det, scl_fall, coll_evt, start_acc;

  always_comb begin
    op_t     = op_e'(op);
    bus_free = p_bit | (~s_bit & ~p_bit);
  end

  i2c_line_mon u_mon (
    .clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in),
    .s_bit(s_bit), .p_bit(p_bit), .start_det(start_det),
    .stop_det(stop_det), .scl_fall(scl_fall)
  );

  i2c_coll_det u_coll (
    .clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in),
    .sda_drv(sda_drv), .op(op_t), .stop_det(stop_det),
    .coll_clr(coll_clr), .start_acc(start_acc), .coll_evt(coll_evt),
    .coll(coll), .irq(irq), .mst_abort(mst_abort), .line_rel(line_rel)
  );

  i2c_tx_track #(.DATA_BITS(DATA_BITS)) u_tx (
    .clk(clk), .rst(rst), .tx_wr(tx_wr), .coll_evt(coll_evt),
    .coll(coll), .op(op_t), .scl_fall(scl_fall),
    .tbf(tbf), .bit_ptr(bit_ptr)
  );

  i2c_cond_ctl u_cond (
    .clk(clk), .rst(rst), .cond_req(cond_req), .cond_done(cond_done),
    .s_bit(s_bit), .coll(coll), .coll_evt(coll_evt), .op(op_t),
    .start_acc(start_acc), .cond_en(cond_en)
  );

  assert_free_tracks_s_R1: assert property (@(posedge clk) disable iff (rst)
    bus_free == !s_bit);
  assert_clr_drops_coll_R10: assert property (@(posedge clk) disable iff (rst)
    (coll && coll_clr && !coll_evt) |=> !coll);
endmodule

// File: tb/test_i2c_arb_guard.sv
module test_i2c_arb_guard;
  logic clk = 1'b0;
  logic rst, sda_in, scl_in, sda_drv, tx_wr, coll_clr;
  logic [2:0] op;
  logic [3:0] cond_req, cond_done;
  logic coll, s_bit, p_bit, bus_free, tbf, irq, mst_abort, line_rel;
  logic [2:0] bit_ptr;
  logic [3:0] cond_en;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2c_arb_guard #(.DATA_BITS(8)) i_i2c_arb_guard (
    .clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in), .sda_drv(sda_drv),
    .op(op), .cond_req(cond_req), .cond_done(cond_done), .tx_wr(tx_wr),
    .coll_clr(coll_clr), .coll(coll), .s_bit(s_bit), .p_bit(p_bit),
    .bus_free(bus_free), .tbf(tbf), .bit_ptr(bit_ptr), .cond_en(cond_en),
    .irq(irq), .mst_abort(mst_abort), .line_rel(line_rel)
  );

  task automatic step();
    @(posedge clk);
    #1;
    cond_req = '0; cond_done = '0; tx_wr = 0; coll_clr = 0;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench model of the S/P status bits
  function automatic logic [1:0] sp_next(logic [1:0] sp, logic ps, logic pc, logic s, logic c);
    if (pc && c && ps && !s) return 2'b10;
    if (pc && c && !ps && s) return 2'b01;
    return sp;
  endfunction

  initial begin
    #(8 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] sp;
    logic ps, pc;
    rst = 1; sda_in = 1; scl_in = 1; sda_drv = 1; op = 0;
    cond_req = 0; cond_done = 0; tx_wr = 0; coll_clr = 0;
    step(); step();
    rst = 0; step();
    // reset state (R1)
    chk("R1 reset s", s_bit, 0); chk("R1 reset p", p_bit, 0);
    chk("R1 reset free", bus_free, 1); chk("R4 reset coll", coll, 0);
    chk("R5 reset tbf", tbf, 0); chk("R9 reset cond", cond_en, 0);
    // start request on a free bus
    cond_req = 4'b0001; step();
    chk("R9 start taken", cond_en, 1);
    sda_in = 0; sda_drv = 0; step();
    chk("R1 start s", s_bit, 1); chk("R1 start p", p_bit, 0); chk("R1 free", bus_free, 0);
    cond_done = 4'b0001; step();
    cond_req = 4'b0001; step();
    chk("R9 start refused busy", cond_en, 0);
    // data byte, three bits then lost arbitration
    scl_in = 0; step();
    sda_in = 1; sda_drv = 1; tx_wr = 1; step();
    chk("R8 write tbf", tbf, 1); chk("R8 write ptr", bit_ptr, 0);
    op = 5;
    for (int i = 0; i < 3; i++) begin
      scl_in = 1; step(); scl_in = 0; step();
    end
    chk("R11 ptr after 3", bit_ptr, 3);
    sda_in = 0; step();
    chk("R3 low scl ignored", coll, 0);
    scl_in = 1; step();
    chk("R4 coll set", coll, 1); chk("R4 irq", irq, 1);
    chk("R4 abort", mst_abort, 1); chk("R4 release", line_rel, 1);
    chk("R5 tbf cleared", tbf, 0); chk("R5 cond kept", cond_en, 0);
    chk("R8 ptr held", bit_ptr, 3);
    op = 0; step();
    chk("R4 irq pulse", irq, 0); chk("R4 abort pulse", mst_abort, 0); chk("R4 sticky", coll, 1);
    sda_in = 1; step();
    chk("R2 stop p", p_bit, 1); chk("R2 stop s", s_bit, 0); chk("R7 stop irq", irq, 1);
    cond_req = 4'b0001; step();
    chk("R7 irq pulse", irq, 0); chk("R9 start refused coll", cond_en, 0);
    tx_wr = 1; step();
    chk("R8 rewrite tbf", tbf, 1); chk("R8 rewrite ptr", bit_ptr, 0);
    coll_clr = 1; step();
    chk("R10 coll cleared", coll, 0); chk("R9 rel held", line_rel, 1);
    cond_req = 4'b0001; step();
    chk("R9 start after clear", cond_en, 1); chk("R9 rel dropped", line_rel, 0);
    // condition collision during acknowledge
    scl_in = 0; step();
    cond_req = 4'b1000; step();
    chk("R6 ack set", cond_en, 9);
    op = 4; sda_drv = 1; sda_in = 0; step();
    chk("R3 low scl ack", coll, 0);
    scl_in = 1; step();
    chk("R6 ack bit cleared", cond_en, 1); chk("R6 tbf kept", tbf, 1); chk("R4 coll ack", coll, 1);
    scl_in = 0; op = 0; step();
    coll_clr = 1; step();
    sda_in = 1; step();
    chk("R10 clear again", coll, 0);
    // full byte
    op = 5;
    for (int i = 0; i < 8; i++) begin
      scl_in = 1; step(); scl_in = 0; step();
      if (i == 6) begin chk("R11 tbf at 7", tbf, 1); chk("R11 ptr at 7", bit_ptr, 7); end
    end
    chk("R11 tbf done", tbf, 0); chk("R11 ptr wrap", bit_ptr, 0);
    op = 0; scl_in = 1; step();
    sda_drv = 1; sda_in = 0; step();
    chk("R3 idle op ignored", coll, 0);
    op = 5; sda_drv = 0; step();
    chk("R3 own low ignored", coll, 0);
    // random line activity with the master idle
    op = 0; sda_drv = 1;
    sp = 2'b10; ps = 0; pc = 1;
    void'($urandom(32'h1d2c));
    for (int n = 0; n < 400; n++) begin
      logic s, c;
      s = 1'($urandom); c = 1'($urandom);
      if (n % 7 == 0) begin c = pc; end
      sda_in = s; scl_in = c; step();
      sp = sp_next(sp, ps, pc, s, c);
      ps = s; pc = c;
      if (s_bit != sp[1]) chk("R1 random s", s_bit, sp[1]);
      if (p_bit != sp[0]) chk("R2 random p", p_bit, sp[0]);
      if (coll) chk("R3 random no coll", coll, 0);
    end
    chk("R1 random final s", s_bit, sp[1]);
    chk("R2 random final p", p_bit, sp[0]);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule